// File: doc/BRIEF.md
# Programmable Settle-and-Average Conversion Sequencer

This block sits between a byte-wide register bus and a simple converter-result port. Software uses it to run one analog-to-digital measurement per request. Software first programs several fields. The channel number and the calibration and decimation selects are forwarded to the front end. An averaging code chooses how many raw samples are collected, and a 4-bit code chooses how long the analog mux settles. A request bit is written last. The sequencer then waits the settle time, measured in microsecond ticks derived from the clock frequency. It requests samples until the programmed count has been accepted and stores the averaged 16-bit result. Finally it raises end-of-conversion status and a one-cycle interrupt.

The configuration registers and the request register occupy consecutive addresses. A run of single-byte writes to rising addresses can therefore configure and launch a conversion with no gap between them. A channel number above the supported maximum does not start sampling. It ends at once with a fault flag, and the stored result is left unchanged.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, status (0x08) and both result bytes (0x50, 0x51) read 0x00, and `eoc_irq` and `sample_req` are low.
- R2: Registers 0x42 to 0x46 read back the full byte last written, and 0x47 always reads 0x00. In 0x42, bit 6 drives `cal_val`, bits 5:4 drive `cal_sel` and bits 3:2 drive `dec_sel`.
- R3: A write of bit 7 = 1 to 0x47 starts a conversion only when bit 7 of 0x46 is 1. Otherwise status and `sample_req` do not change.
- R4: In status (0x08), bit 0 is end-of-conversion, bit 1 is pending and bit 7 is fault. Accepting a valid request clears bits 0 and 7 and sets bit 1, so the register reads 0x02 from the cycle after the request write.
- R5: Bits 3:0 of 0x45 select the settle time. Codes 0..7 give 15, 100, 200, ..., 700 µs. Codes 8..15 give 1, 2, 4, ..., 128 ms. `sample_req` rises exactly settle_us × CLK_MHZ clock cycles after the edge that accepts the request.
- R6: When bit 7 of 0x43 is 1, 2^n samples are collected, where n is bits 2:0 of 0x43, and the result is their sum shifted right by n. When bit 7 is 0, a single sample is taken and stored unchanged.
- R7: The result is read as its low byte at 0x50 and its high byte at 0x51. After a successful conversion, status reads 0x01.
- R8: Each completed conversion gives a one-cycle `eoc_irq` pulse. The pulse comes in the same cycle that end-of-conversion first reads as set.
- R9: A request with a channel number (0x44) above MAX_CHANNEL collects no samples. It ends on the accepting edge with status 0x81 and one interrupt pulse, and the previous result is kept.
- R10: Consecutive-cycle writes to 0x42, 0x43, 0x44, 0x45, 0x46 and then 0x47 launch a conversion that uses the configuration written in that same burst.
- R11: A request written while a conversion is in progress is ignored. It changes neither the settle timing nor the number of results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 8 | Read address |
| bus_rdata | output | 8 | Read data (combinational) |
| sample_req | output | 1 | High while samples are wanted |
| sample_ch | output | 8 | Channel latched at launch |
| sample_valid | input | 1 | A raw sample is presented |
| sample_data | input | 16 | Raw sample value |
| cal_val | output | 1 | Calibration value select |
| cal_sel | output | 2 | Calibration method select |
| dec_sel | output | 2 | Decimation ratio select |
| eoc_irq | output | 1 | One-cycle completion pulse |

## Verification
Conversions are run with averaging disabled, with averaging enabled at n = 0, 2, 5 and 7, and with settle codes taken from both halves of the table. This separates the count and the shift of the averaging path, and the microsecond steps from the millisecond powers of two. Two channels sit on either side of the limit: the maximum legal channel must convert normally and the next one must fault. One launch is made with the enable bit clear and one request is repeated during a busy conversion. Together they show whether requests are gated and ignored at the right moments. One burst launch checks that configuration and request take effect in the same sequence of writes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int RES_W = 16;
  localparam int US_W  = 17;

  localparam logic [7:0] ADDR_STATUS = 8'h08;
  localparam logic [7:0] ADDR_DIG    = 8'h42;
  localparam logic [7:0] ADDR_AVG    = 8'h43;
  localparam logic [7:0] ADDR_CHAN   = 8'h44;
  localparam logic [7:0] ADDR_SETTLE = 8'h45;
  localparam logic [7:0] ADDR_ENABLE = 8'h46;
  localparam logic [7:0] ADDR_REQ    = 8'h47;
  localparam logic [7:0] ADDR_RES_LO = 8'h50;
  localparam logic [7:0] ADDR_RES_HI = 8'h51;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2
  } seq_state_e;

  // Settle code to microseconds: linear 100 us steps (code 0 is 15 us),
  // then 1 ms doubling for the upper eight codes.
  function automatic logic [US_W-1:0] settle_us(input logic [3:0] code);
    logic [US_W-1:0] v;
    if (!code[3]) begin
      if (code[2:0] == 3'd0) v = US_W'(15);
      else                   v = US_W'(code[2:0]) * US_W'(100);
    end else begin
      v = US_W'(1000) << code[2:0];
    end
    return v;
  endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  input  logic [7:0]       status_byte,
  input  logic [RES_W-1:0] result,
  output logic [7:0]       rd_data,
  output logic [7:0]       dig_q,
  output logic [7:0]       avg_q,
  output logic [7:0]       chan_q,
  output logic [7:0]       settle_q,
  output logic [7:0]       enable_q,
  output logic             req_strobe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q    <= '0;
      avg_q    <= '0;
      chan_q   <= '0;
      settle_q <= '0;
      enable_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_DIG:    dig_q    <= wr_data;
        ADDR_AVG:    avg_q    <= wr_data;
        ADDR_CHAN:   chan_q   <= wr_data;
        ADDR_SETTLE: settle_q <= wr_data;
        ADDR_ENABLE: enable_q <= wr_data;
        default: ;
      endcase
    end
  end

  // The request register has no storage: bit 7 is a strobe.
  assign req_strobe = wr_en && (wr_addr == ADDR_REQ) && wr_data[7];

  always_comb begin
    case (rd_addr)
      ADDR_STATUS: rd_data = status_byte;
      ADDR_DIG:    rd_data = dig_q;
      ADDR_AVG:    rd_data = avg_q;
      ADDR_CHAN:   rd_data = chan_q;
      ADDR_SETTLE: rd_data = settle_q;
      ADDR_ENABLE: rd_data = enable_q;
      ADDR_RES_LO: rd_data = result[7:0];
      ADDR_RES_HI: rd_data = result[15:8];
      default:     rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer
  import adc_seq_pkg::*;
#(
  parameter int TICKS_PER_US = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            done,
  output logic            running
);

  localparam int PC_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(TICKS_PER_US - 1);

  logic [PC_W-1:0] pc;
  logic [US_W-1:0] us_left;
  logic            us_tick;

  assign us_tick = running && (pc == PC_LAST);
  assign done    = us_tick && (us_left == US_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      us_left <= '0;
      running <= 1'b0;
    end else if (load) begin
      pc      <= '0;
      us_left <= load_us;
      running <= 1'b1;
    end else if (running) begin
      pc <= us_tick ? '0 : pc + PC_W'(1);
      if (us_tick) begin
        if (us_left == US_W'(1)) running <= 1'b0;
        else                     us_left <= us_left - US_W'(1);
      end
    end
  end

  assert_load_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_us != '0));

  assert_done_ends_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !running);

endmodule

// File: rtl/adc_avg_accum.sv
module adc_avg_accum #(
  parameter int DATA_W = 16,
  parameter int N_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [N_W-1:0]    n_in,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] sample_data,
  output logic              last,
  output logic [DATA_W-1:0] avg
);

  localparam int MAX_N = (1 << N_W) - 1;
  localparam int CNT_W = MAX_N + 1;
  localparam int SUM_W = DATA_W + MAX_N;

  logic [N_W-1:0]   n_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] sum_next;

  function automatic logic [DATA_W-1:0] mean_of(input logic [SUM_W-1:0] s,
                                                 input logic [N_W-1:0]   n);
    return DATA_W'(s >> n);
  endfunction

  assign target   = CNT_W'(1) << n_q;
  assign sum_next = sum + SUM_W'(sample_data);
  assign last     = sample_en && (cnt == target - CNT_W'(1));
  assign avg      = mean_of(sum_next, n_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      cnt <= '0;
      sum <= '0;
    end else if (clear) begin
      n_q <= n_in;
      cnt <= '0;
      sum <= '0;
    end else if (sample_en) begin
      if (last) begin
        cnt <= '0;
        sum <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
        sum <= sum_next;
      end
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < target);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int         CLK_MHZ     = 50,
  parameter logic [7:0] MAX_CHANNEL = 8'd63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_waddr,
  input  logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_raddr,
  output logic [7:0]  bus_rdata,
  output logic        sample_req,
  output logic [7:0]  sample_ch,
  input  logic        sample_valid,
  input  logic [15:0] sample_data,
  output logic        cal_val,
  output logic [1:0]  cal_sel,
  output logic [1:0]  dec_sel,
  output logic        eoc_irq
);

  localparam int N_W = 3;

  logic [7:0]       dig_q, avg_q, chan_q, settle_q, enable_q;
  logic             req_strobe;
  logic [7:0]       status_byte;
  logic [RES_W-1:0] result_q;
  seq_state_e       state;
  logic             eoc_q, pending_q, fault_q;

  // Named internal events
  logic             launch;
  logic             bad_chan;
  logic             timer_load;
  logic             timer_done;
  logic             timer_running;
  logic             acc_sample;
  logic             acc_last;
  logic [RES_W-1:0] acc_avg;
  logic [N_W-1:0]   avg_n;

  assign status_byte = {fault_q, 5'b0, pending_q, eoc_q};

  adc_seq_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (bus_we),
    .wr_addr     (bus_waddr),
    .wr_data     (bus_wdata),
    .rd_addr     (bus_raddr),
    .status_byte (status_byte),
    .result      (result_q),
    .rd_data     (bus_rdata),
    .dig_q       (dig_q),
    .avg_q       (avg_q),
    .chan_q      (chan_q),
    .settle_q    (settle_q),
    .enable_q    (enable_q),
    .req_strobe  (req_strobe)
  );

  assign cal_val = dig_q[6];
  assign cal_sel = dig_q[5:4];
  assign dec_sel = dig_q[3:2];

  assign launch     = req_strobe && enable_q[7] && (state == ST_IDLE);
  assign bad_chan   = chan_q > MAX_CHANNEL;
  assign timer_load = launch && !bad_chan;
  assign avg_n      = avg_q[7] ? avg_q[N_W-1:0] : '0;
  assign acc_sample = (state == ST_SAMPLE) && sample_valid;
  assign sample_req = (state == ST_SAMPLE);

  adc_settle_timer #(.TICKS_PER_US(CLK_MHZ)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .load_us (settle_us(settle_q[3:0])),
    .done    (timer_done),
    .running (timer_running)
  );

  adc_avg_accum #(.DATA_W(RES_W), .N_W(N_W)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (launch),
    .n_in        (avg_n),
    .sample_en   (acc_sample),
    .sample_data (sample_data),
    .last        (acc_last),
    .avg         (acc_avg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      eoc_q     <= 1'b0;
      pending_q <= 1'b0;
      fault_q   <= 1'b0;
      eoc_irq   <= 1'b0;
      result_q  <= '0;
      sample_ch <= '0;
    end else begin
      eoc_irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            if (bad_chan) begin
              fault_q   <= 1'b1;
              eoc_q     <= 1'b1;
              pending_q <= 1'b0;
              eoc_irq   <= 1'b1;
            end else begin
              fault_q   <= 1'b0;
              eoc_q     <= 1'b0;
              pending_q <= 1'b1;
              sample_ch <= chan_q;
              state     <= ST_SETTLE;
            end
          end
        end
        ST_SETTLE: begin
          if (timer_done) state <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          if (acc_last) begin
            result_q  <= acc_avg;
            eoc_q     <= 1'b1;
            pending_q <= 1'b0;
            eoc_irq   <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  assert_irq_with_eoc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> (eoc_q && !pending_q));

  assert_sampling_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> (pending_q && !eoc_q && !fault_q));

  assert_timer_in_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timer_running |-> (state == ST_SETTLE));

  assert_fault_no_sampling_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> !sample_req);

  assert_busy_ignores_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && state != ST_IDLE) |=> !$rose(pending_q));

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TPU        = 2;
  localparam int MAXCH      = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_waddr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_raddr = '0;
  logic [7:0]  bus_rdata;
  logic        sample_req;
  logic [7:0]  sample_ch;
  logic        sample_valid = 1'b0;
  logic [15:0] sample_data = '0;
  logic        cal_val;
  logic [1:0]  cal_sel;
  logic [1:0]  dec_sel;
  logic        eoc_irq;

  int checks = 0;
  int errors = 0;
  int samp_idx = 0;
  int irq_seen = 0;
  int irq_expect = 0;
  logic [15:0] last_res = '0;
  logic [15:0] exp_res_q[$];
  logic [7:0]  exp_stat_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.CLK_MHZ(TPU), .MAX_CHANNEL(8'(MAXCH))) u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .sample_req(sample_req), .sample_ch(sample_ch),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .cal_val(cal_val), .cal_sel(cal_sel), .dec_sel(dec_sel),
    .eoc_irq(eoc_irq)
  );

  function automatic int gen(int k);
    return (k * 2731 + 977) % 65536;
  endfunction

  function automatic int settle_table(int code);
    case (code)
      0: return 15;     1: return 100;    2: return 200;    3: return 300;
      4: return 400;    5: return 500;    6: return 600;    7: return 700;
      8: return 1000;   9: return 2000;   10: return 4000;  11: return 8000;
      12: return 16000; 13: return 32000; 14: return 64000; default: return 128000;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_we = 1'b0;
  endtask

  // Converter stub
  initial begin
    forever begin
      @(negedge clk);
      if (sample_req) begin
        sample_valid = 1'b1;
        sample_data  = 16'(gen(samp_idx));
        samp_idx++;
      end else begin
        sample_valid = 1'b0;
      end
    end
  end

  // Monitor: pops expected items on each interrupt
  initial begin
    logic [7:0] s, lo, hi;
    forever begin
      @(negedge clk);
      if (eoc_irq) begin
        irq_seen++;
        rd(8'h08, s);
        rd(8'h50, lo);
        rd(8'h51, hi);
        if (exp_res_q.size() == 0) begin
          chk("R11 unexpected completion", 1, 0);
        end else begin
          chk("R8/R7 status at irq", s, exp_stat_q.pop_front());
          chk("R6/R7 result", {hi, lo}, exp_res_q.pop_front());
        end
        @(negedge clk);
        chk("R8 irq one cycle", eoc_irq, 0);
      end
    end
  end

  task automatic run_conv(int ch, int code, logic [7:0] avg, bit burst, bit extra);
    int n, cnt, sum, k;
    logic [7:0] s;
    int base;
    bit bad;
    bad  = (ch > MAXCH);
    base = samp_idx;
    n    = avg[7] ? int'(avg[2:0]) : 0;
    cnt  = 1 << n;
    sum  = 0;
    for (int i = 0; i < cnt; i++) sum += gen(base + i);
    if (bad) begin
      exp_res_q.push_back(last_res);
      exp_stat_q.push_back(8'h81);
    end else begin
      last_res = 16'(sum >> n);
      exp_res_q.push_back(last_res);
      exp_stat_q.push_back(8'h01);
    end
    irq_expect++;
    if (burst) begin
      // R10: consecutive-cycle writes 0x42..0x47
      wr(8'h42, 8'h14); wr(8'h43, avg); wr(8'h44, 8'(ch));
      wr(8'h45, 8'(code)); wr(8'h46, 8'h80); wr(8'h47, 8'h80);
    end else begin
      wr(8'h43, avg); wr(8'h44, 8'(ch)); wr(8'h45, 8'(code)); wr(8'h46, 8'h80);
      repeat (2) @(negedge clk);
      wr(8'h47, 8'h80);
    end
    if (bad) begin
      while (irq_seen < irq_expect) @(posedge clk);
      repeat (3) @(negedge clk);
      chk("R9 no samples taken", samp_idx, base);
      return;
    end
    rd(8'h08, s);
    chk("R4 status after launch", s, 8'h02);
    k = 0;
    forever begin
      @(negedge clk);
      if (sample_req) break;
      if (extra && k == 3) begin
        bus_we = 1'b1; bus_waddr = 8'h47; bus_wdata = 8'h80;
      end else begin
        bus_we = 1'b0;
      end
      @(posedge clk);
      k++;
    end
    bus_we = 1'b0;
    chk(extra ? "R5/R11 settle cycles" : (burst ? "R5/R10 settle cycles" : "R5 settle cycles"),
        k, settle_table(code) * TPU);
    chk("sample_ch", sample_ch, ch);
    while (irq_seen < irq_expect) @(posedge clk);
    repeat (3) @(negedge clk);
    chk("R6 sample count", samp_idx - base, cnt);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(8'h08, d); chk("R1 status reset", d, 0);
    rd(8'h50, d); chk("R1 result lo reset", d, 0);
    rd(8'h51, d); chk("R1 result hi reset", d, 0);
    chk("R1 irq reset", eoc_irq, 0);
    chk("R1 sample_req reset", sample_req, 0);
    // R2
    wr(8'h42, 8'hE6); wr(8'h45, 8'hA3); wr(8'h43, 8'h5A);
    @(negedge clk);
    rd(8'h42, d); chk("R2 dig readback", d, 8'hE6);
    rd(8'h45, d); chk("R2 settle readback", d, 8'hA3);
    rd(8'h43, d); chk("R2 avg readback", d, 8'h5A);
    rd(8'h47, d); chk("R2 request reads zero", d, 0);
    chk("R2 cal_val", cal_val, 1);
    chk("R2 cal_sel", cal_sel, 2);
    chk("R2 dec_sel", dec_sel, 1);
    // R3: enable clear
    wr(8'h46, 8'h00); wr(8'h47, 8'h80);
    repeat (5) @(negedge clk);
    chk("R3 no sampling when disabled", sample_req, 0);
    rd(8'h08, d); chk("R3 status unchanged", d, 0);
    chk("R3 no irq", irq_seen, 0);
    // Conversions
    run_conv(3,  0, 8'h82, 1'b0, 1'b0);
    run_conv(5,  1, 8'h03, 1'b0, 1'b0);
    run_conv(MAXCH, 8, 8'h85, 1'b0, 1'b1);
    run_conv(MAXCH + 1, 2, 8'h81, 1'b0, 1'b0);
    run_conv(10, 9, 8'h80, 1'b1, 1'b0);
    run_conv(7,  7, 8'h87, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R11 irq count", irq_seen, irq_expect);
    chk("R11 scoreboard drained", exp_res_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule